// File: doc/BRIEF.md
# UART Register Bank

This block is the bus-side register file of a serial port. A single request port carries reads and writes of 16 bits. The block decodes each request into one of twelve 8-bit registers placed 4 bytes apart, applies the side effects of that register, and answers one cycle later with read data and a response code. The shift logic, baud generator and buffering sit outside the block. They take divisor, framing and control values from its outputs, and they return the live transmitter and receiver status, the received byte, and one-cycle pulses for line errors and clear-to-send changes.

The interrupt enable register has no direct write address. It is changed through a set address and a clear address, and a read of either address returns its value. The sticky error bits of the line status register and the delta bit of the modem status register are cleared by writing 1 to them. A write to the transmit holding register loads the outgoing byte. When the transmit-empty enable is set, the same write also sends a one-cycle event to the transmit side.

Top module: `uart_reg_bank`

## Requirements
- R1: A request is answered on the cycle after it is accepted, with `rsp_valid_o` high and a code on `rsp_code_o`. The code is 1 when `req_size_i` is not 1 (1 means 16 bits), and this holds for any address. The code is 2 when the size is legal but the offset is not a multiple of 4 or the index (offset/4) is above 11. The code is 0 otherwise.
- R2: A request whose code is not 0 changes no register, returns zero read data and raises no transmit event. A write that succeeds returns zero read data.
- R3: Index 0 (divisor low), 1 (divisor high), 2 (global control), 3 (line control), 4 (modem control) and 7 (scratch) are plain storage of `req_wdata_i[7:0]`. Reads return the byte with the upper 8 bits zero. `divisor_o` = {index 1, index 0}, and `gctl_o`, `lcr_o` and `mcr_o` show indices 2, 3 and 4.
- R4: A write to index 8 ORs the written byte into the interrupt enable register.
- R5: A write to index 9 clears every enable bit written as 1. A read of index 8 or of index 9 returns the enable register.
- R6: Line status (index 5) holds sticky bits OE=bit1, PE=bit2, FE=bit3, BI=bit4 and TFI=bit7, which `line_evt_i[0..4]` set in that order. Writing 1 to one of these bits clears it. Writes have no effect on bits 0, 5 and 6. An event wins over a clear of the same bit in the same cycle.
- R7: A read of line status returns bit0=`rx_dr_i`, bit5=`tx_thre_i` and bit6=`tx_temt_i`, sampled in the cycle of the read, together with the sticky bits.
- R8: Modem status (index 6) bit0 is set by `cts_chg_i` and cleared by writing 1 to bit0. Its other bits read 0.
- R9: Writes to index 11 are ignored. A read of index 11 returns `rx_byte_i`.
- R10: A write to index 10 loads `tx_byte_o`, and a read of index 10 returns it. When enable bit1 was set before the write, `tx_event_o` is high for exactly the response cycle of that write. At all other times it is low.
- R11: After reset all registers are 0, `rsp_valid_o` and `tx_event_o` are low, and line status reads 0x60 while the transmitter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Access size: 0 = 8, 1 = 16, 2 = 32 bits |
| req_addr_i | input | ADDR_W | Byte offset |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_code_o | output | 2 | 0 ok, 1 bad size, 2 bad address |
| rsp_rdata_o | output | DATA_W | Read data |
| rx_dr_i | input | 1 | Live receive data ready |
| tx_thre_i | input | 1 | Live holding register empty |
| tx_temt_i | input | 1 | Live transmitter empty |
| rx_byte_i | input | REG_W | Most recent received byte |
| line_evt_i | input | 5 | Error pulses {TFI, BI, FE, PE, OE} |
| cts_chg_i | input | 1 | Clear-to-send change pulse |
| divisor_o | output | 2*REG_W | Baud divisor |
| gctl_o | output | REG_W | Global control |
| lcr_o | output | REG_W | Line control |
| mcr_o | output | REG_W | Modem control |
| tx_byte_o | output | REG_W | Transmit holding byte |
| tx_event_o | output | 1 | Transmit event pulse |

## Verification
The bench goes through every offset with every size. A decoder that checked the address before the size would report code 2 for offsets that are misaligned and also of the wrong size. A decoder that ignored the stride or the end of the map would accept offsets that are not in the map. Bad-size writes of all ones are sent to every offset with the transmit enable on. A design that let such writes through would corrupt storage or pulse the transmit event. The bench also sends a clear of a line error in the same cycle as a new error event, and a design that gives the clear priority would lose that error. Writes of 0xFF to line status check that the live bits do not latch, and a write to the receive buffer checks that it does not land in storage.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int NUM_REGS = 12;

  typedef enum logic [3:0] {
    RI_DLL     = 4'd0,
    RI_DLH     = 4'd1,
    RI_GCTL    = 4'd2,
    RI_LCR     = 4'd3,
    RI_MCR     = 4'd4,
    RI_LSR     = 4'd5,
    RI_MSR     = 4'd6,
    RI_SCR     = 4'd7,
    RI_IER_SET = 4'd8,
    RI_IER_CLR = 4'd9,
    RI_THR     = 4'd10,
    RI_RBR     = 4'd11
  } reg_idx_e;

  typedef enum logic [1:0] {
    RSP_OK   = 2'd0,
    RSP_SIZE = 2'd1,
    RSP_ADDR = 2'd2
  } rsp_e;

  localparam logic [1:0] SIZE_HALF = 2'd1;
  // plain storage: indices 0..4 and 7
  localparam logic [NUM_REGS-1:0] PLAIN_MASK = 12'b0000_1001_1111;
  localparam int IER_ETBEI = 1;
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode import uart_rb_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic [1:0]          size_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] hit_o,
  output rsp_e                code_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             in_map;

  assign idx    = addr_i[ADDR_W-1:2];
  assign in_map = (addr_i[1:0] == 2'b00) && (idx < IDX_W'(NUM_REGS));

  // size check outranks address check
  always_comb begin
    if (size_i != SIZE_HALF)  code_o = RSP_SIZE;
    else if (!in_map)         code_o = RSP_ADDR;
    else                      code_o = RSP_OK;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign hit_o[g] = (code_o == RSP_OK) && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/uart_rb_status.sv
module uart_rb_status import uart_rb_pkg::*; #(
  parameter int REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lsr_wr_i,
  input  logic             msr_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [4:0]       line_evt_i,
  input  logic             cts_chg_i,
  input  logic             rx_dr_i,
  input  logic             tx_thre_i,
  input  logic             tx_temt_i,
  output logic [REG_W-1:0] lsr_o,
  output logic [REG_W-1:0] msr_o
);
  // sticky order {TFI, BI, FE, PE, OE}
  logic [4:0] stk_q;
  logic [4:0] wsel;
  logic       scts_q;

  assign wsel = lsr_wr_i ? {wdata_i[7], wdata_i[4:1]} : 5'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stk_q  <= '0;
      scts_q <= 1'b0;
    end else begin
      stk_q  <= (stk_q & ~wsel) | line_evt_i;
      scts_q <= (scts_q & ~(msr_wr_i & wdata_i[0])) | cts_chg_i;
    end
  end

  // live bits are sampled at read time
  assign lsr_o = {stk_q[4], tx_temt_i, tx_thre_i, stk_q[3:0], rx_dr_i};
  assign msr_o = {{(REG_W-1){1'b0}}, scts_q};

  // R6
  lsr_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_wr_i && line_evt_i == 5'b0) |=> ((stk_q & $past(wsel)) == 5'b0));
  // R6
  lsr_evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_evt_i != 5'b0) |=> ((stk_q & $past(line_evt_i)) == $past(line_evt_i)));
  // R8
  scts_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_wr_i && wdata_i[0] && !cts_chg_i) |=> !scts_q);
endmodule

// File: rtl/uart_reg_bank.sv
module uart_reg_bank import uart_rb_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [1:0]          req_size_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                rsp_valid_o,
  output logic [1:0]          rsp_code_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  input  logic                rx_dr_i,
  input  logic                tx_thre_i,
  input  logic                tx_temt_i,
  input  logic [REG_W-1:0]    rx_byte_i,
  input  logic [4:0]          line_evt_i,
  input  logic                cts_chg_i,
  output logic [2*REG_W-1:0]  divisor_o,
  output logic [REG_W-1:0]    gctl_o,
  output logic [REG_W-1:0]    lcr_o,
  output logic [REG_W-1:0]    mcr_o,
  output logic [REG_W-1:0]    tx_byte_o,
  output logic                tx_event_o
);
  rsp_e                code;
  logic [NUM_REGS-1:0] hit, wr_sel;
  logic                wr_ok, rd_ok;
  logic [REG_W-1:0]    wb, rd_val, lsr_v, msr_v;
  logic [REG_W-1:0]    plain_q [NUM_REGS];
  logic [REG_W-1:0]    ier_q, thr_q;
  logic                tx_evt_q, rsp_valid_q;
  rsp_e                rsp_code_q;
  logic [DATA_W-1:0]   rsp_rdata_q;
  logic                unused_hi;

  assign wb        = req_wdata_i[REG_W-1:0];
  assign unused_hi = ^req_wdata_i[DATA_W-1:REG_W];

  uart_rb_decode #(.ADDR_W(ADDR_W)) i_decode (
    .size_i (req_size_i),
    .addr_i (req_addr_i),
    .hit_o  (hit),
    .code_o (code)
  );

  assign wr_ok  = req_valid_i && req_write_i && (code == RSP_OK);
  assign rd_ok  = req_valid_i && !req_write_i && (code == RSP_OK);
  assign wr_sel = hit & {NUM_REGS{wr_ok}};

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_plain
    if (PLAIN_MASK[g]) begin : g_store
      logic [REG_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        q <= '0;
        else if (wr_sel[g]) q <= wb;
      end
      assign plain_q[g] = q;
    end else begin : g_none
      assign plain_q[g] = '0;
    end
  end

  uart_rb_status #(.REG_W(REG_W)) i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lsr_wr_i   (wr_sel[RI_LSR]),
    .msr_wr_i   (wr_sel[RI_MSR]),
    .wdata_i    (wb),
    .line_evt_i (line_evt_i),
    .cts_chg_i  (cts_chg_i),
    .rx_dr_i    (rx_dr_i),
    .tx_thre_i  (tx_thre_i),
    .tx_temt_i  (tx_temt_i),
    .lsr_o      (lsr_v),
    .msr_o      (msr_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q    <= '0;
      thr_q    <= '0;
      tx_evt_q <= 1'b0;
    end else begin
      if (wr_sel[RI_IER_SET])      ier_q <= ier_q | wb;
      else if (wr_sel[RI_IER_CLR]) ier_q <= ier_q & ~wb;
      if (wr_sel[RI_THR])          thr_q <= wb;
      // enable as it stood before this write
      tx_evt_q <= wr_sel[RI_THR] & ier_q[IER_ETBEI];
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (hit[i]) rd_val = plain_q[i];
    if (hit[RI_LSR])                     rd_val = lsr_v;
    if (hit[RI_MSR])                     rd_val = msr_v;
    if (hit[RI_IER_SET] || hit[RI_IER_CLR]) rd_val = ier_q;
    if (hit[RI_THR])                     rd_val = thr_q;
    if (hit[RI_RBR])                     rd_val = rx_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= RSP_OK;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_code_q  <= req_valid_i ? code : RSP_OK;
      rsp_rdata_q <= rd_ok ? {{(DATA_W-REG_W){1'b0}}, rd_val} : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_code_o  = rsp_code_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign divisor_o   = {plain_q[RI_DLH], plain_q[RI_DLL]};
  assign gctl_o      = plain_q[RI_GCTL];
  assign lcr_o       = plain_q[RI_LCR];
  assign mcr_o       = plain_q[RI_MCR];
  assign tx_byte_o   = thr_q;
  assign tx_event_o  = tx_evt_q;

  // R1
  size_err_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i != SIZE_HALF) |=> (rsp_code_o == RSP_SIZE));
  // R2
  err_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_code_o != RSP_OK) |-> (rsp_rdata_o == '0 && !tx_event_o));
  // R10
  tx_evt_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_event_o |-> $past(req_valid_i && req_write_i && req_size_i == SIZE_HALF
                         && req_addr_i == ADDR_W'(RI_THR * 4)));
  // R4
  ier_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel[RI_IER_SET] |=> ((ier_q & $past(wb)) == $past(wb)));
  // R5
  ier_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel[RI_IER_CLR] |=> ((ier_q & $past(wb)) == '0));
endmodule

// File: tb/test_uart_reg_bank.sv
`timescale 1ns/1ps
module test_uart_reg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [15:0] rsp_rdata;
  logic        rx_dr = 1'b0, tx_thre = 1'b1, tx_temt = 1'b1;
  logic [7:0]  rx_byte = 8'h5A;
  logic [4:0]  line_evt = '0;
  logic        cts_chg = 1'b0;
  logic [15:0] divisor;
  logic [7:0]  gctl, lcr, mcr, tx_byte;
  logic        tx_event;

  int n_chk = 0, n_bad = 0;
  logic        r_valid, r_evt;
  logic [1:0]  r_code;
  logic [15:0] r_data;

  // reference model
  logic [7:0] m_plain [12];
  logic [7:0] m_ier = '0, m_thr = '0;
  logic [4:0] m_stk = '0;
  logic       m_scts = 1'b0;

  always #2.5 clk = ~clk;

  uart_reg_bank i_uart_reg_bank (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_size_i(req_size),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code), .rsp_rdata_o(rsp_rdata),
    .rx_dr_i(rx_dr), .tx_thre_i(tx_thre), .tx_temt_i(tx_temt), .rx_byte_i(rx_byte),
    .line_evt_i(line_evt), .cts_chg_i(cts_chg),
    .divisor_o(divisor), .gctl_o(gctl), .lcr_o(lcr), .mcr_o(mcr),
    .tx_byte_o(tx_byte), .tx_event_o(tx_event)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [5:0] a, input logic [1:0] sz,
                        input logic [15:0] wd, input logic [4:0] evt = 5'b0,
                        input logic cts = 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    line_evt = evt; cts_chg = cts;
    @(negedge clk);
    r_valid = rsp_valid; r_code = rsp_code; r_data = rsp_rdata; r_evt = tx_event;
    req_valid = 1'b0; req_write = 1'b0; line_evt = '0; cts_chg = 1'b0;
  endtask

  function automatic logic [1:0] exp_code(input int a, input int s);
    if (s != 1) return 2'd1;
    if ((a % 4) != 0 || (a / 4) > 11) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [15:0] exp_read(input int idx);
    case (idx)
      5:       return {8'h0, m_stk[4], tx_temt, tx_thre, m_stk[3:0], rx_dr};
      6:       return {15'h0, m_scts};
      8, 9:    return {8'h0, m_ier};
      10:      return {8'h0, m_thr};
      11:      return {8'h0, rx_byte};
      default: return {8'h0, m_plain[idx]};
    endcase
  endfunction

  task automatic rd_chk(input string req, input int idx);
    access(1'b0, 6'(idx * 4), 2'd1, 16'h0);
    check(req, {16'h0, r_data}, {16'h0, exp_read(idx)});
  endtask

  // model of a legal write (events handled by caller)
  task automatic wr_model(input int idx, input logic [15:0] wd);
    logic [7:0] b;
    b = wd[7:0];
    case (idx)
      0, 1, 2, 3, 4, 7: m_plain[idx] = b;
      5:  m_stk  = m_stk & ~{b[7], b[4:1]};
      6:  if (b[0]) m_scts = 1'b0;
      8:  m_ier  = m_ier | b;
      9:  m_ier  = m_ier & ~b;
      10: m_thr  = b;
      default: ;
    endcase
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 12; i++) m_plain[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 valid", {31'h0, rsp_valid}, 0);
    check("R11 tx_event", {31'h0, tx_event}, 0);
    check("R11 divisor", {16'h0, divisor}, 0);
    check("R11 tx_byte", {24'h0, tx_byte}, 0);
    rd_chk("R11 lsr idle", 5);
    check("R11 lsr value", {16'h0, r_data}, 32'h60);

    // R1 R2: read sweep over all offsets and sizes
    for (int a = 0; a < 64; a++)
      for (int s = 0; s < 4; s++) begin
        access(1'b0, 6'(a), 2'(s), 16'h0);
        check("R1 valid", {31'h0, r_valid}, 1);
        check("R1 code", {30'h0, r_code}, {30'h0, exp_code(a, s)});
        if (exp_code(a, s) != 2'd0) check("R2 rdata zero", {16'h0, r_data}, 0);
        else check("R3 reset read", {16'h0, r_data}, {16'h0, exp_read(a / 4)});
      end

    // R2: illegal writes with transmit enable on
    access(1'b1, 6'd32, 2'd1, 16'h0002); wr_model(8, 16'h0002);
    for (int a = 0; a < 64; a++)
      for (int s = 0; s < 4; s++)
        if (exp_code(a, s) != 2'd0) begin
          access(1'b1, 6'(a), 2'(s), 16'hFFFF);
          check("R2 no tx event", {31'h0, r_evt}, 0);
          check("R2 code", {30'h0, r_code}, {30'h0, exp_code(a, s)});
        end
    for (int i = 0; i < 12; i++) rd_chk("R2 state kept", i);
    check("R2 divisor", {16'h0, divisor}, 0);

    // R3 plain storage
    for (int p = 0; p < 3; p++)
      for (int i = 0; i < 8; i++)
        if (i != 5 && i != 6) begin
          logic [15:0] wd;
          wd = (16'hA55A ^ 16'(i * 16'h1111)) + 16'(p * 37);
          access(1'b1, 6'(i * 4), 2'd1, wd); wr_model(i, wd);
          check("R2 write rdata zero", {16'h0, r_data}, 0);
          rd_chk("R3 plain readback", i);
        end
    check("R3 divisor_o", {16'h0, divisor}, {16'h0, m_plain[1], m_plain[0]});
    check("R3 gctl_o", {24'h0, gctl}, {24'h0, m_plain[2]});
    check("R3 lcr_o", {24'h0, lcr}, {24'h0, m_plain[3]});
    check("R3 mcr_o", {24'h0, mcr}, {24'h0, m_plain[4]});

    // R4 R5 enable set/clear
    access(1'b1, 6'd36, 2'd1, 16'hFFFF); wr_model(9, 16'hFFFF);
    rd_chk("R5 cleared", 9);
    access(1'b1, 6'd32, 2'd1, 16'h0005); wr_model(8, 16'h0005);
    access(1'b1, 6'd32, 2'd1, 16'hFF0A); wr_model(8, 16'hFF0A);
    rd_chk("R4 set or", 8);
    rd_chk("R5 read via clear", 9);
    check("R4 value", {16'h0, r_data}, 32'h0F);
    access(1'b1, 6'd36, 2'd1, 16'h0006); wr_model(9, 16'h0006);
    rd_chk("R5 clear ones", 8);
    check("R5 value", {16'h0, r_data}, 32'h09);

    // R10 transmit
    access(1'b1, 6'd40, 2'd1, 16'h1234); wr_model(10, 16'h1234);
    check("R10 no event when disabled", {31'h0, r_evt}, 0);
    check("R10 tx_byte", {24'h0, tx_byte}, 32'h34);
    access(1'b1, 6'd32, 2'd1, 16'h0002); wr_model(8, 16'h0002);
    access(1'b1, 6'd40, 2'd1, 16'h00AB); wr_model(10, 16'h00AB);
    check("R10 event pulse", {31'h0, r_evt}, 1);
    @(negedge clk);
    check("R10 event one cycle", {31'h0, tx_event}, 0);
    rd_chk("R10 thr readback", 10);
    check("R10 no event on read", {31'h0, r_evt}, 0);

    // R6 R7 line status
    access(1'b0, 6'd28, 2'd1, 16'h0, 5'h1F); m_stk = m_stk | 5'h1F;
    rx_dr = 1'b1; tx_thre = 1'b0; tx_temt = 1'b0;
    rd_chk("R7 live bits", 5);
    check("R7 value", {16'h0, r_data}, 32'h9F);
    access(1'b1, 6'd20, 2'd1, 16'h000A); wr_model(5, 16'h000A);
    rd_chk("R6 w1c partial", 5);
    access(1'b1, 6'd20, 2'd1, 16'h0061); wr_model(5, 16'h0061);
    rd_chk("R6 live bits ignore writes", 5);
    rx_dr = 1'b0; tx_thre = 1'b1; tx_temt = 1'b1;
    access(1'b0, 6'd28, 2'd1, 16'h0, 5'h1F); m_stk = 5'h1F;
    access(1'b1, 6'd20, 2'd1, 16'h00FF, 5'h01);
    m_stk = (m_stk & ~5'h1F) | 5'h01;
    rd_chk("R6 event wins", 5);
    check("R6 value", {16'h0, r_data}, 32'h62);

    // R8 modem status
    access(1'b0, 6'd28, 2'd1, 16'h0, 5'h0, 1'b1); m_scts = 1'b1;
    rd_chk("R8 set", 6);
    access(1'b1, 6'd24, 2'd1, 16'hFFFE); wr_model(6, 16'hFFFE);
    rd_chk("R8 other bits no clear", 6);
    check("R8 value", {16'h0, r_data}, 1);
    access(1'b1, 6'd24, 2'd1, 16'h0001); wr_model(6, 16'h0001);
    rd_chk("R8 cleared", 6);

    // R9 receive buffer
    access(1'b1, 6'd44, 2'd1, 16'h0077);
    check("R9 write no event", {31'h0, r_evt}, 0);
    rd_chk("R9 rx byte", 11);
    rx_byte = 8'hC3;
    rd_chk("R9 rx byte new", 11);
    for (int i = 0; i < 11; i++) rd_chk("R9 write ignored", i);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule